// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a protocol controller's transmit line and the driver enable of a single-wire bus transceiver. The transmit input is active low: a low level asks the driver to pull the bus dominant, and a high level releases the driver so the bus pull-up returns it to recessive. The driver request is a combinational function of the current inputs, so a permitted transmit low reaches the driver in the same cycle.

A run counter watches how long the transmit line stays low. If the low lasts for the full dominant timeout, a lockout latches. The lockout forces the driver off and raises a status flag. A single rising edge on the transmit line does not clear the lockout. The line must stay high for a whole qualifying release interval, and a shorter high pulse only restarts that count. The driver is also held off whenever the operating mode does not permit transmission, when the supply is flagged as undervoltage, or while a thermal fault is signalled. The timeout defaults to about 9 ms and the release interval to 10 µs, both at a 250 MHz clock, and both are parameters in clock cycles.

Top module: `txd_dom_guard`

## Requirements
- R1: `drv_dom_o` is 1 in the same cycle exactly when `txd_i`=0, `tx_mode_ok_i`=1, `uv_fault_i`=0, `thermal_fault_i`=0 and `tout_flag_o`=0; otherwise it is 0.
- R2: When `txd_i` is sampled 0 on TIMEOUT_CYC consecutive rising clock edges, `tout_flag_o` becomes 1 after the last of those edges, and `drv_dom_o` is 0 from then on.
- R3: A low run of TIMEOUT_CYC-1 edges followed by a high sample does not set the lockout, and the next low run counts again from zero.
- R4: While locked, `txd_i` sampled 1 on RELEASE_CYC consecutive edges clears `tout_flag_o` after the last of those edges, and a following low on `txd_i` drives dominant again.
- R5: While locked, a high on `txd_i` that lasts fewer than RELEASE_CYC edges leaves the lockout set, and the release count starts again from zero at the next high.
- R6: `tx_mode_ok_i`=0 or `uv_fault_i`=1 forces `drv_dom_o` to 0.
- R7: `thermal_fault_i`=1 forces `drv_dom_o` to 0, and driving resumes in the cycle the fault clears without any lockout being set.
- R8: The timeout counter counts low samples of `txd_i` whether or not transmission is permitted. It clears on every high sample and holds at its terminal count without wrapping.
- R9: Synchronous active-high `rst` clears the lockout and both counters, so `tout_flag_o`=0 after reset.
- R10: `tout_flag_o` is 1 exactly while the lockout is set. It keeps the driver off while it is 1, and the driver is permitted again in the cycle it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_i | input | 1 | Sampled transmit level, 0 = dominant request |
| tx_mode_ok_i | input | 1 | 1 when the operating mode permits transmission |
| uv_fault_i | input | 1 | 1 when the supply is below the undervoltage threshold |
| thermal_fault_i | input | 1 | 1 while thermal shutdown is signalled |
| drv_dom_o | output | 1 | 1 asks the driver to pull the bus dominant |
| tout_flag_o | output | 1 | 1 while the dominant-timeout lockout is active |

## Verification
The bench walks a table of every combination of transmit level and the three blocking inputs, which shows that each blocker alone suppresses the driver and that nothing else does. Low runs of TIMEOUT_CYC-1 and TIMEOUT_CYC edges test the exact edge where the lockout latches. Release runs of RELEASE_CYC-1 edges, an interrupting low pulse, and then a full RELEASE_CYC run show that a plain rising edge does not re-arm the block. A long low held with transmission disabled shows that the timeout counts the line level rather than the gated output. A thermal pulse shows recovery with no lockout.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [0:0] {
        GUARD_ARMED  = 1'b0,
        GUARD_LOCKED = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic txd_low;
        logic mode_ok;
        logic uv_fault;
        logic thermal_fault;
        logic locked;
    } drive_req_t;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic drive_allowed(input drive_req_t r);
        return r.txd_low & r.mode_ok & ~r.uv_fault & ~r.thermal_fault & ~r.locked;
    endfunction

endpackage

// File: rtl/txg_run_counter.sv
module txg_run_counter
    import txg_pkg::*;
#(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic hit
);
    localparam int unsigned CW = cnt_bits(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = active && (cnt == LAST);

    // R8: bounded, cleared when idle, holds at terminal count
    a_r8_counter_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);
    a_r8_clear_on_idle: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));
    a_r8_hold_at_top: assert property (@(posedge clk) disable iff (rst)
        (active && cnt == TOP) |=> (cnt == TOP));

endmodule

// File: rtl/txg_lock_ctrl.sv
module txg_lock_ctrl
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dom_hit,
    input  logic rel_hit,
    output logic locked
);
    guard_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GUARD_ARMED:  if (dom_hit) state_nx = GUARD_LOCKED;
            GUARD_LOCKED: if (rel_hit) state_nx = GUARD_ARMED;
            default:      state_nx = GUARD_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GUARD_ARMED;
        else     state <= state_nx;
    end

    assign locked = (state == GUARD_LOCKED);

    // R5: without a completed release run the lockout persists
    a_r5_hold_lock: assert property (@(posedge clk) disable iff (rst)
        (locked && !rel_hit) |=> locked);
    // R3: without a completed dominant run the guard stays armed
    a_r3_stay_armed: assert property (@(posedge clk) disable iff (rst)
        (!locked && !dom_hit) |=> !locked);

endmodule

// File: rtl/txg_drive_gate.sv
module txg_drive_gate
    import txg_pkg::*;
(
    input  drive_req_t req,
    output logic       drv_dom
);
    assign drv_dom = drive_allowed(req);
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
    import txg_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 2250000,
    parameter int unsigned RELEASE_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic txd_i,
    input  logic tx_mode_ok_i,
    input  logic uv_fault_i,
    input  logic thermal_fault_i,
    output logic drv_dom_o,
    output logic tout_flag_o
);
    logic       locked;
    logic       dom_hit;
    logic       rel_hit;
    drive_req_t req;

    txg_run_counter #(.LIMIT(TIMEOUT_CYC)) u_dom_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (~txd_i),
        .hit    (dom_hit)
    );

    txg_run_counter #(.LIMIT(RELEASE_CYC)) u_rel_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (locked & txd_i),
        .hit    (rel_hit)
    );

    txg_lock_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .dom_hit (dom_hit),
        .rel_hit (rel_hit),
        .locked  (locked)
    );

    always_comb begin
        req.txd_low       = ~txd_i;
        req.mode_ok       = tx_mode_ok_i;
        req.uv_fault      = uv_fault_i;
        req.thermal_fault = thermal_fault_i;
        req.locked        = locked;
    end

    txg_drive_gate u_gate (
        .req     (req),
        .drv_dom (drv_dom_o)
    );

    assign tout_flag_o = locked;

    a_r1_drive_follows: assert property (@(posedge clk) disable iff (rst)
        (!txd_i && tx_mode_ok_i && !uv_fault_i && !thermal_fault_i && !tout_flag_o)
        |-> drv_dom_o);
    a_r10_no_drive_locked: assert property (@(posedge clk) disable iff (rst)
        tout_flag_o |-> !drv_dom_o);
    a_r2_flag_rise_after_low: assert property (@(posedge clk) disable iff (rst)
        $rose(tout_flag_o) |-> $past(!txd_i));
    a_r4_flag_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        $fell(tout_flag_o) |-> $past(txd_i));
    a_r6_mode_uv_block: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode_ok_i || uv_fault_i) |-> !drv_dom_o);
    a_r7_thermal_block: assert property (@(posedge clk) disable iff (rst)
        thermal_fault_i |-> !drv_dom_o);

endmodule

// File: tb/txd_dom_guard_bench.sv
module txd_dom_guard_bench;
    localparam int unsigned T = 20;
    localparam int unsigned R = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd = 1'b1;
    logic mode_ok = 1'b1;
    logic uv = 1'b0;
    logic therm = 1'b0;
    logic drv;
    logic flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    txd_dom_guard #(.TIMEOUT_CYC(T), .RELEASE_CYC(R)) u_txd_dom_guard (
        .clk             (clk),
        .rst             (rst),
        .txd_i           (txd),
        .tx_mode_ok_i    (mode_ok),
        .uv_fault_i      (uv),
        .thermal_fault_i (therm),
        .drv_dom_o       (drv),
        .tout_flag_o     (flag)
    );

    // {txd, mode_ok, uv, therm, expected drv}
    localparam logic [4:0] VEC [0:15] = '{
        5'b0_1_0_0_1, 5'b1_1_0_0_0, 5'b0_0_0_0_0, 5'b0_1_1_0_0,
        5'b0_1_0_1_0, 5'b0_0_1_0_0, 5'b0_0_0_1_0, 5'b0_1_1_1_0,
        5'b0_0_1_1_0, 5'b1_0_0_0_0, 5'b1_1_1_0_0, 5'b1_1_0_1_0,
        5'b1_0_1_1_0, 5'b1_0_1_0_0, 5'b1_0_0_1_0, 5'b1_1_1_1_0
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        txd = 1'b0;
        edges(3);
        chk("R9 flag in reset", flag, 1'b0);
        rst = 1'b0;
        txd = 1'b1;
        edges(1);
        chk("R9 flag after reset", flag, 1'b0);

        // R1/R6/R7 vector table; a high cycle between entries clears the run
        for (int v = 0; v < 16; v++) begin
            {txd, mode_ok, uv, therm} = VEC[v][4:1];
            #1;
            chk("R1/R6/R7 vector", drv, VEC[v][0]);
            edges(1);
            txd = 1'b1;
            edges(1);
        end
        mode_ok = 1'b1; uv = 1'b0; therm = 1'b0;

        // R3: T-1 lows then a high, no lockout; new run restarts from zero
        txd = 1'b0;
        edges(T - 1);
        chk("R3 no lock at T-1", flag, 1'b0);
        chk("R3 still driving", drv, 1'b1);
        txd = 1'b1;
        edges(1);
        txd = 1'b0;
        edges(T - 1);
        chk("R3 restarted run", flag, 1'b0);

        // R2: T-th low edge latches
        edges(1);
        chk("R2 flag after T lows", flag, 1'b1);
        chk("R2 driver off", drv, 1'b0);
        edges(10);
        chk("R10 flag held while low", flag, 1'b1);
        chk("R10 driver held off", drv, 1'b0);

        // R5: short high keeps lock
        txd = 1'b1;
        edges(R - 1);
        chk("R5 flag after R-1 highs", flag, 1'b1);
        txd = 1'b0;
        #1;
        chk("R5 no drive after short high", drv, 1'b0);
        edges(1);
        txd = 1'b1;
        edges(R - 1);
        chk("R5 count restarted", flag, 1'b1);

        // R4: complete release
        edges(1);
        chk("R4 flag cleared", flag, 1'b0);
        txd = 1'b0;
        #1;
        chk("R4 drive after release", drv, 1'b1);
        edges(T - 1);
        chk("R4 fresh timeout run", flag, 1'b0);
        txd = 1'b1;
        edges(1);

        // R7: thermal pulse then resume without lockout
        txd = 1'b0;
        therm = 1'b1;
        #1;
        chk("R7 thermal blocks", drv, 1'b0);
        edges(3);
        therm = 1'b0;
        #1;
        chk("R7 resume after fault", drv, 1'b1);
        chk("R7 no lockout", flag, 1'b0);
        txd = 1'b1;
        edges(1);

        // R8: timeout counts while transmission disabled
        mode_ok = 1'b0;
        txd = 1'b0;
        edges(T);
        chk("R8 lock with mode off", flag, 1'b1);
        edges(3 * T);
        chk("R8 saturated, no wrap", flag, 1'b1);
        mode_ok = 1'b1;
        #1;
        chk("R10 locked, mode on", drv, 1'b0);
        txd = 1'b1;
        edges(R);
        chk("R10 flag clears", flag, 1'b0);
        txd = 1'b0;
        #1;
        chk("R10 driver permitted", drv, 1'b1);

        // R9: reset mid-lockout
        edges(T);
        chk("R2 relock", flag, 1'b1);
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        #1;
        chk("R9 reset clears lock", flag, 1'b0);
        chk("R9 drive after reset", drv, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule